// File: doc/BRIEF.md
# MDIO Management Slave

This block is the PHY side of a two-wire serial management link. The management clock is its clock. The data line is bidirectional and is shared with the master. The slave samples the line on every rising clock edge. It waits for a long run of ones followed by a start marker, then reads the opcode, the PHY address and the register address. The frame is served only when its PHY address is the all-zero broadcast value or matches the address strapped on the `phy_strap` pins.

For an accepted read, the slave takes over the line for the second half of the turnaround and for the sixteen data bits. It then hands the line back on the next clock edge. For an accepted write, the slave only listens and updates the addressed register when the last data bit arrives. The line is not driven through a true tri-state pin. The slave provides a data value and a separate enable for an external buffer.

The register bank is small: a writable control word whose value leaves the block on `ctrl_reg`, a read-only status word and two read-only identifier words. All other addresses read as zero and discard writes.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A frame starts only after at least 32 consecutive ones are sampled, followed by the start marker 0 then 1. A shorter run of ones is not a frame. A second marker bit of 0 returns the slave to hunting for ones, so the bits that follow are ignored.
- R2: Opcode bits (the first two after the marker, first bit in bit 1) of 2'b10 mean read and 2'b01 mean write. Opcodes 2'b00 and 2'b11 are ignored: no register changes and the line is never driven.
- R3: The 5-bit PHY address arrives MSB first. The frame is accepted when that address is 5'b00000 or equals `phy_strap`. Otherwise the rest of the frame (18 bits) is skipped, no write happens and `mdio_oe` stays 0.
- R4: The 5-bit register address follows the PHY address, MSB first, and selects the register that is read or written.
- R5: On an accepted read, `mdio_oe` stays 0 through the first turnaround bit time. It rises with `mdio_out` at 0 on the edge that samples the first turnaround bit.
- R6: On a write, `mdio_oe` stays 0 for the whole frame. The two turnaround bits the master sends are not checked.
- R7: Data is 16 bits, MSB first, in both directions. On a read, bit 15 is presented on the edge that samples the second turnaround bit, and each later edge presents the next lower bit.
- R8: Address 0 is the control register. It resets to 16'h3100, is read and written in full, and its value is visible on `ctrl_reg`. Address 1 is the status register, a constant 16'h7849 that writes do not change.
- R9: Addresses 2 and 3 return the constants 16'h1A2B and 16'h3C4D and ignore writes. Every address from 4 to 31 reads 16'h0000 and discards writes.
- R10: `mdio_oe` falls on the edge that samples the time slot of the last read data bit. A write appears on `ctrl_reg` one edge after the edge that samples its last data bit.
- R11: While `rst_n` is low, `mdio_oe` is 0 and `ctrl_reg` is 16'h3100, even when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_strap | input | 5 | Strapped PHY address this slave answers to |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_out | output | 1 | Value for the external buffer to drive onto the line |
| mdio_oe | output | 1 | Enable for the external buffer; 1 means the slave drives |
| ctrl_reg | output | 16 | Current content of the control register |

## Verification
The assertions check on every cycle that the slave drives the line only while it is serving a read, and that each drive period opens with a zero turnaround bit and lasts at most seventeen bit times. They also check that the line is released whenever the slave is hunting for a preamble, that the write strobe is a single pulse, and that the control word changes only after that pulse. Other behaviour can only be shown by the bench's frame scenarios: the bit order of the data returned on reads, address filtering (including broadcast), the preamble length limit, recovery from a bad start marker, writes to read-only and unmapped addresses, and reset in the middle of a read.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_START,
        PH_HDR,
        PH_READ,
        PH_WRITE,
        PH_SKIP
    } phase_e;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] strap,
    input  logic              mdio_in,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              mdio_oe,
    output logic              mdio_out,
    output phase_e            phase
);

    localparam int OP_W       = 2;
    localparam int HDR_BITS   = OP_W + PHY_AW + REG_AW;
    localparam int TA_BITS    = 2;
    localparam int DATA_FIRST = HDR_BITS + TA_BITS;
    localparam int LAST_IDX   = DATA_FIRST + DW - 1;
    localparam int BCW        = $clog2(LAST_IDX + 1);
    localparam int PCW        = $clog2(PRE_LEN + 1);

    typedef struct packed {
        phase_e                ph;
        logic [PCW-1:0]        pre_cnt;
        logic [BCW-1:0]        idx;
        logic [HDR_BITS-1:0]   hdr;
        logic [DW-1:0]         data;
        logic                  oe;
        logic                  dout;
        logic                  wr_en;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    logic [HDR_BITS-1:0] hdr_nx;
    logic [OP_W-1:0]     op_nx;
    logic [PHY_AW-1:0]   pa_nx;
    logic                addr_hit;

    assign hdr_nx   = {st_q.hdr[HDR_BITS-2:0], mdio_in};
    assign op_nx    = hdr_nx[HDR_BITS-1 -: OP_W];
    assign pa_nx    = hdr_nx[REG_AW +: PHY_AW];
    assign addr_hit = (pa_nx == '0) || (pa_nx == strap);
    assign rd_addr  = hdr_nx[REG_AW-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        case (st_q.ph)
            PH_HUNT: begin
                if (mdio_in) begin
                    if (st_q.pre_cnt != PCW'(PRE_LEN))
                        st_d.pre_cnt = st_q.pre_cnt + PCW'(1);
                end else if (st_q.pre_cnt == PCW'(PRE_LEN)) begin
                    st_d.ph      = PH_START;
                    st_d.pre_cnt = '0;
                end else begin
                    st_d.pre_cnt = '0;
                end
            end
            PH_START: begin
                st_d.pre_cnt = '0;
                st_d.idx     = '0;
                st_d.hdr     = '0;
                st_d.ph      = mdio_in ? PH_HDR : PH_HUNT;
            end
            PH_HDR: begin
                st_d.hdr = hdr_nx;
                st_d.idx = st_q.idx + BCW'(1);
                if (st_q.idx == BCW'(HDR_BITS - 1)) begin
                    if (addr_hit && op_nx == OPC_RD) begin
                        st_d.ph   = PH_READ;
                        st_d.data = rd_data;
                    end else if (addr_hit && op_nx == OPC_WR) begin
                        st_d.ph = PH_WRITE;
                    end else begin
                        st_d.ph = PH_SKIP;
                    end
                end
            end
            PH_READ: begin
                st_d.idx = st_q.idx + BCW'(1);
                if (st_q.idx == BCW'(HDR_BITS)) begin
                    st_d.oe   = 1'b1;
                    st_d.dout = 1'b0;
                end else if (st_q.idx == BCW'(LAST_IDX)) begin
                    st_d.oe      = 1'b0;
                    st_d.dout    = 1'b0;
                    st_d.ph      = PH_HUNT;
                    st_d.pre_cnt = '0;
                end else begin
                    st_d.dout = st_q.data[DW-1];
                    st_d.data = {st_q.data[DW-2:0], 1'b0};
                end
            end
            PH_WRITE: begin
                st_d.idx = st_q.idx + BCW'(1);
                if (st_q.idx >= BCW'(DATA_FIRST))
                    st_d.data = {st_q.data[DW-2:0], mdio_in};
                if (st_q.idx == BCW'(LAST_IDX)) begin
                    st_d.wr_en   = 1'b1;
                    st_d.ph      = PH_HUNT;
                    st_d.pre_cnt = '0;
                end
            end
            PH_SKIP: begin
                st_d.idx = st_q.idx + BCW'(1);
                if (st_q.idx == BCW'(LAST_IDX)) begin
                    st_d.ph      = PH_HUNT;
                    st_d.pre_cnt = '0;
                end
            end
            default: begin
                st_d.ph      = PH_HUNT;
                st_d.pre_cnt = '0;
                st_d.oe      = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_HUNT, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.hdr[REG_AW-1:0];
    assign wr_data  = st_q.data;
    assign mdio_oe  = st_q.oe;
    assign mdio_out = st_q.dout;
    assign phase    = st_q.ph;

endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
    parameter int          REG_AW     = 5,
    parameter int          DW         = 16,
    parameter logic [15:0] CTRL_RESET = 16'h3100,
    parameter logic [15:0] STATUS_VAL = 16'h7849,
    parameter logic [15:0] ID_HI      = 16'h1A2B,
    parameter logic [15:0] ID_LO      = 16'h3C4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     ctrl_reg
);

    localparam logic [REG_AW-1:0] A_CTRL   = REG_AW'(0);
    localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(1);
    localparam logic [REG_AW-1:0] A_ID_HI  = REG_AW'(2);
    localparam logic [REG_AW-1:0] A_ID_LO  = REG_AW'(3);

    logic [DW-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == A_CTRL)
            ctrl_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= DW'(CTRL_RESET);
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = ctrl_q;
            A_STATUS: rd_data = DW'(STATUS_VAL);
            A_ID_HI:  rd_data = DW'(ID_HI);
            A_ID_LO:  rd_data = DW'(ID_LO);
            default:  rd_data = '0;
        endcase
    end

    assign ctrl_reg = ctrl_q;

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int          PHY_AW     = 5,
    parameter int          REG_AW     = 5,
    parameter int          DW         = 16,
    parameter int          PRE_LEN    = 32,
    parameter logic [15:0] CTRL_RESET = 16'h3100,
    parameter logic [15:0] STATUS_VAL = 16'h7849,
    parameter logic [15:0] ID_HI      = 16'h1A2B,
    parameter logic [15:0] ID_LO      = 16'h3C4D
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] phy_strap,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DW-1:0]     ctrl_reg
);

    logic [REG_AW-1:0] rd_addr;
    logic [DW-1:0]     rd_data;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [DW-1:0]     wr_data;
    phase_e            phase;

    mgmt_frame_fsm #(
        .PHY_AW (PHY_AW),
        .REG_AW (REG_AW),
        .DW     (DW),
        .PRE_LEN(PRE_LEN)
    ) u_fsm (
        .clk     (mdc),
        .rst_n   (rst_n),
        .strap   (phy_strap),
        .mdio_in (mdio_in),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mdio_oe (mdio_oe),
        .mdio_out(mdio_out),
        .phase   (phase)
    );

    mgmt_reg_bank #(
        .REG_AW    (REG_AW),
        .DW        (DW),
        .CTRL_RESET(CTRL_RESET),
        .STATUS_VAL(STATUS_VAL),
        .ID_HI     (ID_HI),
        .ID_LO     (ID_LO)
    ) u_bank (
        .clk     (mdc),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_reg(ctrl_reg)
    );

endmodule

// File: rtl/mgmt_serial_slave_chk.sv
module mgmt_serial_slave_chk
    import mgmt_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mdio_oe,
    input logic          mdio_out,
    input phase_e        phase,
    input logic          wr_en,
    input logic [DW-1:0] ctrl_reg
);

    logic [5:0] drive_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       drive_run <= '0;
        else if (mdio_oe) drive_run <= drive_run + 6'd1;
        else              drive_run <= '0;
    end

    // R6 / R3: the line is driven only while a read is being served
    p_oe_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (phase == PH_READ));

    // R5: the first driven bit of a read is the zero turnaround bit
    p_ta_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R7: one drive period covers at most the turnaround bit and the data bits
    p_drive_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_run <= 6'(DW + 1));

    // R10: line released whenever the slave hunts for a preamble
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HUNT) |-> !mdio_oe);

    // R10: the write strobe lasts a single cycle
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: the control word changes only after a write strobe
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_reg));

endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk #(.DW(16)) u_chk (
    .clk     (mdc),
    .rst_n   (rst_n),
    .mdio_oe (mdio_oe),
    .mdio_out(mdio_out),
    .phase   (phase),
    .wr_en   (wr_en),
    .ctrl_reg(ctrl_reg)
);

// File: tb/mgmt_serial_slave_tb.sv
module mgmt_serial_slave_tb;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_strap = 5'h0B;
    logic        mst_en = 1'b1;
    logic        mst_val = 1'b1;
    logic        mdio_in;
    logic        mdio_out;
    logic        mdio_oe;
    logic [15:0] ctrl_reg;

    int total = 0;
    int bad   = 0;

    always #4 mdc = ~mdc;

    // shared line: slave buffer, else master, else pull-up
    assign mdio_in = mdio_oe ? mdio_out : (mst_en ? mst_val : 1'b1);

    mgmt_serial_slave u_dut (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .phy_strap(phy_strap),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .ctrl_reg (ctrl_reg)
    );

    localparam logic [1:0] RD = 2'b10;
    localparam logic [1:0] WR = 2'b01;
    localparam int NV = 17;

    // {op, phy, reg, wdata, expected rdata, expected ctrl, expect drive}
    localparam logic [60:0] VEC [NV] = '{
        {RD,    5'h0B, 5'h00, 16'h0000, 16'h3100, 16'h3100, 1'b1}, // R8 R7
        {RD,    5'h00, 5'h01, 16'h0000, 16'h7849, 16'h3100, 1'b1}, // R3 broadcast
        {WR,    5'h0B, 5'h00, 16'hA5C3, 16'h0000, 16'hA5C3, 1'b0}, // R6 R8
        {RD,    5'h0B, 5'h00, 16'h0000, 16'hA5C3, 16'hA5C3, 1'b1}, // R8
        {WR,    5'h0B, 5'h01, 16'hFFFF, 16'h0000, 16'hA5C3, 1'b0}, // R8 status RO
        {RD,    5'h0B, 5'h01, 16'h0000, 16'h7849, 16'hA5C3, 1'b1}, // R8
        {RD,    5'h0B, 5'h02, 16'h0000, 16'h1A2B, 16'hA5C3, 1'b1}, // R9 R4
        {RD,    5'h00, 5'h03, 16'h0000, 16'h3C4D, 16'hA5C3, 1'b1}, // R9 R4
        {WR,    5'h0C, 5'h00, 16'h0000, 16'h0000, 16'hA5C3, 1'b0}, // R3 mismatch
        {RD,    5'h0C, 5'h00, 16'h0000, 16'h0000, 16'hA5C3, 1'b0}, // R3 mismatch
        {WR,    5'h00, 5'h05, 16'h1234, 16'h0000, 16'hA5C3, 1'b0}, // R9 unmapped
        {RD,    5'h0B, 5'h05, 16'h0000, 16'h0000, 16'hA5C3, 1'b1}, // R9 reads 0
        {2'b00, 5'h0B, 5'h00, 16'h0000, 16'h0000, 16'hA5C3, 1'b0}, // R2
        {2'b11, 5'h0B, 5'h00, 16'h0000, 16'h0000, 16'hA5C3, 1'b0}, // R2
        {WR,    5'h00, 5'h00, 16'h8001, 16'h0000, 16'h8001, 1'b0}, // R7 R10
        {RD,    5'h0B, 5'h00, 16'h0000, 16'h8001, 16'h8001, 1'b1}, // R7
        {RD,    5'h1F, 5'h00, 16'h0000, 16'h0000, 16'h8001, 1'b0}  // R3
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One frame, preceded by a single 0 so the preamble count starts clean.
    task automatic run_frame(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                             input bit drv_exp, input int cut,
                             output logic [15:0] rd, output int oe_bad);
        logic [11:0] hdr;
        bit          rd_op;
        hdr    = {op, pa, ra};
        rd_op  = (op == RD);
        rd     = '0;
        oe_bad = 0;
        @(negedge mdc);
        mst_en  = 1'b1;
        mst_val = 1'b0;
        for (int j = 0; j < pre_len + 2 + 32; j++) begin
            int  i;
            bit  exp_oe;
            i = j - pre_len - 2;
            @(negedge mdc);
            if (i == cut) break;
            exp_oe = drv_exp && (i >= 13) && (i <= 29);
            if (mdio_oe !== exp_oe) oe_bad++;
            if (drv_exp && i == 13 && mdio_out !== 1'b0) oe_bad++;
            if (drv_exp && i >= 14 && i <= 29) rd[29-i] = mdio_out;
            mst_en = 1'b1;
            if (j < pre_len)     mst_val = 1'b1;
            else if (i < 0)      mst_val = st[-i-1];
            else if (i < 12)     mst_val = hdr[11-i];
            else if (i >= 30)    mst_val = 1'b1;
            else if (rd_op)      mst_en  = 1'b0;
            else if (i == 12)    mst_val = 1'b1;
            else if (i == 13)    mst_val = 1'b0;
            else                 mst_val = wd[29-i];
        end
        mst_en  = 1'b1;
        mst_val = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          oe_bad;

        repeat (3) @(negedge mdc);
        check("R11 reset oe", {15'd0, mdio_oe}, 16'h0000);
        check("R11 reset ctrl", ctrl_reg, 16'h3100);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [60:0] v;
            v = VEC[k];
            run_frame(32, 2'b01, v[60:59], v[58:54], v[53:49], v[48:33], v[0], 99, rd, oe_bad);
            if (v[0]) check("R7 R5 read data", rd, v[32:17]);
            check("R5 R6 R3 line drive pattern", 16'(oe_bad), 16'h0000);
            check("R8 R9 R10 ctrl after frame", ctrl_reg, v[16:1]);
        end

        // R1: 31 ones is too short
        run_frame(31, 2'b01, WR, 5'h0B, 5'h00, 16'h5555, 1'b0, 99, rd, oe_bad);
        check("R1 short preamble ctrl", ctrl_reg, 16'h8001);
        check("R1 short preamble drive", 16'(oe_bad), 16'h0000);

        // R1: bad start marker returns to hunting
        run_frame(32, 2'b00, WR, 5'h0B, 5'h00, 16'h5555, 1'b0, 99, rd, oe_bad);
        check("R1 bad start ctrl", ctrl_reg, 16'h8001);

        // R1: recovery with a proper frame
        run_frame(32, 2'b01, WR, 5'h0B, 5'h00, 16'h5555, 1'b0, 99, rd, oe_bad);
        check("R1 recovery write", ctrl_reg, 16'h5555);

        // R1: long preamble accepted
        run_frame(45, 2'b01, RD, 5'h0B, 5'h00, 16'h0000, 1'b1, 99, rd, oe_bad);
        check("R1 long preamble read", rd, 16'h5555);
        check("R1 long preamble drive", 16'(oe_bad), 16'h0000);

        // R11: reset in the middle of a read
        run_frame(32, 2'b01, RD, 5'h0B, 5'h00, 16'h0000, 1'b1, 20, rd, oe_bad);
        check("R5 partial read drive", 16'(oe_bad), 16'h0000);
        rst_n = 1'b0;
        #1;
        check("R11 mid-frame reset oe", {15'd0, mdio_oe}, 16'h0000);
        check("R11 mid-frame reset ctrl", ctrl_reg, 16'h3100);
        @(negedge mdc);
        rst_n = 1'b1;

        // R4 after reset: line works again
        run_frame(32, 2'b01, RD, 5'h00, 5'h02, 16'h0000, 1'b1, 99, rd, oe_bad);
        check("R4 read after reset", rd, 16'h1A2B);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule